// File: doc/BRIEF.md
# I2C Register Access Slave

This block is a serial-bus slave through which an off-chip I2C master reads and writes the memories and registers of a chip. It never starts a transfer itself. SCL and SDA are sampled with the system clock through a short synchronizer. Start and stop conditions come from the relative timing of the two lines. The open-drain SDA pull-down is given as an output-enable: a high `sda_oe` means the pad pulls SDA low.

A transfer opens with a device byte. Its upper seven bits must equal a fixed five-bit prefix (`01101` by default) followed by the two board strap inputs, which gives the byte values 0x68 to 0x6F. Its lowest bit selects the direction, with 1 for a read. A write continues with a 16-bit subaddress, high byte first, because the internal memories are too large for one address byte. Every byte after that is data. Data is gathered into words whose length depends on the region the subaddress points into: short words below a boundary address and long words at or above it. Each complete word becomes one write strobe on a parallel bus, and the subaddress then steps by one, so bursts of any length are possible.

A read uses the subaddress left by the most recent write, normally set through a repeated start. The block strobes a read on the internal bus before the first data bit goes out. Each word is then sent most significant byte first, and the next word is fetched whenever the master acknowledges the last byte of the current one.

Top module: `i2c_regport`

## Requirements
- R1: During and directly after reset, `sda_oe`, `bus_we` and `bus_re` are low.
- R2: A start is SDA falling while SCL is high. The next eight bits are taken MSB first. When their upper seven bits equal {`01101`, `dev_sel[1]`, `dev_sel[0]`}, the block pulls SDA low throughout the ninth clock.
- R3: A device byte that does not match is not acknowledged. The block then drives nothing and strobes nothing until the next start.
- R4: In a write, the two bytes after the device byte form the subaddress, high byte first. No bus strobe is raised during the address bytes, and every data byte is acknowledged. `bus_we` and `bus_re` are never high together.
- R5: A word has 2 bytes when the subaddress is below 0x0800 and 4 bytes otherwise. One single-cycle `bus_we` pulse follows the last byte of each word, carrying that subaddress and the word's bytes packed first-byte-most-significant and right-aligned in `bus_wdata`.
- R6: After each complete word, the subaddress advances by one, both in writes and in reads.
- R7: Bytes of an incomplete word that is cut off by a stop or a start produce no write.
- R8: With R/W = 1, a single-cycle `bus_re` pulse carries the current subaddress before the first data bit. The word read is sent most significant byte first, MSB first within each byte. The next word is read when the master acknowledges the last byte of the current one.
- R9: After a master NACK, the block releases SDA and issues no further read strobe until the next start.
- R10: A stop (SDA rising while SCL is high) returns the block to idle. A repeated start begins a new device byte and keeps the subaddress.
- R11: `sda_oe` only becomes active while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 = pull SDA low |
| dev_sel | input | 2 | Board straps, [1] then [0] in the device address |
| bus_addr | output | 16 | Internal bus address |
| bus_wdata | output | 32 | Write word, right-aligned |
| bus_we | output | 1 | Write strobe, one cycle |
| bus_re | output | 1 | Read strobe, one cycle |
| bus_rdata | input | 32 | Read word, valid the cycle after `bus_re` |

## Verification
The bench probes the region boundary at 0x0800. A block that picked the word length wrongly would strobe after the wrong byte count and shift read bytes out of alignment. It cuts words short with a stop, where a design that flushed partial words would corrupt memory, and it ends reads with a NACK, where a design that kept driving would collide with the master's stop. It also varies the strap pins against mismatched device bytes, to catch acknowledgments sent to other devices. Finally, it reads back through a repeated start, which fails if the subaddress is lost on restart or the first read strobe comes too late for bit 7.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;
  localparam int SUB_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK
  } st_e;

  typedef enum logic [1:0] {
    PH_DEV,
    PH_SUBH,
    PH_SUBL,
    PH_DATA
  } ph_e;
endpackage

// File: rtl/i2c_regport_cond.sv
module i2c_regport_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_chain;
  logic [SYNC_STAGES-1:0] sda_chain;
  logic scl_s, scl_q, sda_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_chain <= '1;
          sda_chain <= '1;
        end else begin
          scl_chain <= scl_i;
          sda_chain <= sda_i;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_chain <= '1;
          sda_chain <= '1;
        end else begin
          scl_chain <= {scl_chain[SYNC_STAGES-2:0], scl_i};
          sda_chain <= {sda_chain[SYNC_STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  assign scl_s = scl_chain[SYNC_STAGES-1];
  assign sda_s = sda_chain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_regport_wsize.sv
module i2c_regport_wsize #(
  parameter int          SUB_W        = 16,
  parameter int          CNT_W        = 3,
  parameter int          NARROW_BYTES = 2,
  parameter int          WIDE_BYTES   = 4,
  parameter logic [15:0] WIDE_BASE    = 16'h0800
) (
  input  logic [SUB_W-1:0] sub_addr,
  output logic [CNT_W-1:0] word_nb
);
  always_comb begin
    if (sub_addr >= SUB_W'(WIDE_BASE)) word_nb = CNT_W'(WIDE_BYTES);
    else                               word_nb = CNT_W'(NARROW_BYTES);
  end
endmodule

// File: rtl/i2c_regport_ctrl.sv
module i2c_regport_ctrl
  import i2c_regport_pkg::*;
#(
  parameter int         MAXB       = 4,
  parameter int         CNT_W      = 3,
  parameter logic [4:0] DEV_PREFIX = 5'b01101,
  localparam int        DATA_W     = 8 * MAXB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [1:0]        dev_sel,
  input  logic [CNT_W-1:0]  word_nb,
  output logic [SUB_W-1:0]  sub_addr,
  output logic              sda_oe,
  output logic [SUB_W-1:0]  bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_we,
  output logic              bus_re,
  input  logic [DATA_W-1:0] bus_rdata
);
  st_e               st_q, st_d;
  ph_e               ph_q, ph_d;
  logic [3:0]        bit_q, bit_d;
  logic [7:0]        sh_q, sh_d;
  logic              rw_q, rw_d;
  logic [SUB_W-1:0]  sub_q, sub_d;
  logic [CNT_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] wbuf_q, wbuf_d;
  logic [DATA_W-1:0] rbuf_q, rbuf_d;
  logic              oe_q, oe_d;
  logic              we_q, we_d, re_q, re_d;
  logic [SUB_W-1:0]  addr_q, addr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic [1:0]        pend_q, pend_d;
  logic [7:0]        rx_byte;
  logic [DATA_W-1:0] wword;
  logic              last_byte;
  int                shamt;

  assign rx_byte   = {sh_q[6:0], sda_s};
  assign wword     = {wbuf_q[DATA_W-9:0], rx_byte};
  assign last_byte = (idx_q == word_nb - CNT_W'(1));

  always_comb begin
    st_d    = st_q;
    ph_d    = ph_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    rw_d    = rw_q;
    sub_d   = sub_q;
    idx_d   = idx_q;
    wbuf_d  = wbuf_q;
    rbuf_d  = rbuf_q;
    oe_d    = oe_q;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    we_d    = 1'b0;
    re_d    = 1'b0;
    pend_d  = {pend_q[0], 1'b0};
    shamt   = 8 * (MAXB - int'(word_nb));

    // read word arrives one cycle after the strobe; left-align it
    if (pend_q[1]) rbuf_d = bus_rdata << shamt;

    unique case (st_q)
      ST_IDLE: ;
      ST_RX: begin
        if (scl_rise) begin
          sh_d  = rx_byte;
          bit_d = bit_q + 4'd1;
          if (bit_q == 4'd7) begin
            unique case (ph_q)
              PH_DEV: begin
                if (rx_byte[7:1] == {DEV_PREFIX, dev_sel}) begin
                  rw_d  = rx_byte[0];
                  idx_d = '0;
                  ph_d  = PH_SUBH;
                  if (rx_byte[0]) begin
                    re_d      = 1'b1;
                    addr_d    = sub_q;
                    pend_d[0] = 1'b1;
                  end
                end else begin
                  st_d = ST_IDLE;
                end
              end
              PH_SUBH: begin
                sub_d = {rx_byte, sub_q[7:0]};
                ph_d  = PH_SUBL;
              end
              PH_SUBL: begin
                sub_d  = {sub_q[15:8], rx_byte};
                idx_d  = '0;
                wbuf_d = '0;
                ph_d   = PH_DATA;
              end
              PH_DATA: begin
                if (last_byte) begin
                  we_d    = 1'b1;
                  addr_d  = sub_q;
                  wdata_d = wword;
                  sub_d   = sub_q + SUB_W'(1);
                  idx_d   = '0;
                  wbuf_d  = '0;
                end else begin
                  wbuf_d = wword;
                  idx_d  = idx_q + CNT_W'(1);
                end
              end
              default: ;
            endcase
          end
        end else if (scl_fall && bit_q == 4'd8) begin
          st_d  = ST_ACK;
          oe_d  = 1'b1;
          bit_d = '0;
        end
      end
      ST_ACK: begin
        if (scl_fall) begin
          if (rw_q) begin
            st_d   = ST_TX;
            oe_d   = ~rbuf_q[DATA_W-1];
            rbuf_d = {rbuf_q[DATA_W-2:0], 1'b0};
            bit_d  = 4'd1;
          end else begin
            st_d  = ST_RX;
            oe_d  = 1'b0;
            bit_d = '0;
          end
        end
      end
      ST_TX: begin
        if (scl_fall) begin
          if (bit_q == 4'd8) begin
            st_d = ST_MACK;
            oe_d = 1'b0;
          end else begin
            oe_d   = ~rbuf_q[DATA_W-1];
            rbuf_d = {rbuf_q[DATA_W-2:0], 1'b0};
            bit_d  = bit_q + 4'd1;
          end
        end
      end
      ST_MACK: begin
        if (scl_rise) begin
          if (sda_s) begin
            st_d = ST_IDLE;
          end else if (last_byte) begin
            idx_d     = '0;
            sub_d     = sub_q + SUB_W'(1);
            re_d      = 1'b1;
            addr_d    = sub_q + SUB_W'(1);
            pend_d[0] = 1'b1;
          end else begin
            idx_d = idx_q + CNT_W'(1);
          end
        end else if (scl_fall) begin
          st_d   = ST_TX;
          oe_d   = ~rbuf_q[DATA_W-1];
          rbuf_d = {rbuf_q[DATA_W-2:0], 1'b0};
          bit_d  = 4'd1;
        end
      end
      default: st_d = ST_IDLE;
    endcase

    if (start_det) begin
      st_d  = ST_RX;
      ph_d  = PH_DEV;
      bit_d = '0;
      oe_d  = 1'b0;
    end else if (stop_det) begin
      st_d = ST_IDLE;
      oe_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      ph_q    <= PH_DEV;
      bit_q   <= '0;
      sh_q    <= '0;
      rw_q    <= 1'b0;
      sub_q   <= '0;
      idx_q   <= '0;
      wbuf_q  <= '0;
      rbuf_q  <= '0;
      oe_q    <= 1'b0;
      we_q    <= 1'b0;
      re_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      pend_q  <= '0;
    end else begin
      st_q    <= st_d;
      ph_q    <= ph_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      rw_q    <= rw_d;
      sub_q   <= sub_d;
      idx_q   <= idx_d;
      wbuf_q  <= wbuf_d;
      rbuf_q  <= rbuf_d;
      oe_q    <= oe_d;
      we_q    <= we_d;
      re_q    <= re_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      pend_q  <= pend_d;
    end
  end

  assign sub_addr  = sub_q;
  assign sda_oe    = oe_q;
  assign bus_addr  = addr_q;
  assign bus_wdata = wdata_q;
  assign bus_we    = we_q;
  assign bus_re    = re_q;
endmodule

// File: rtl/i2c_regport.sv
module i2c_regport #(
  parameter int          SYNC_STAGES  = 2,
  parameter int          NARROW_BYTES = 2,
  parameter int          WIDE_BYTES   = 4,
  parameter logic [15:0] WIDE_BASE    = 16'h0800,
  parameter logic [4:0]  DEV_PREFIX   = 5'b01101,
  localparam int         MAXB   = (WIDE_BYTES > NARROW_BYTES) ? WIDE_BYTES : NARROW_BYTES,
  localparam int         DATA_W = 8 * MAXB,
  localparam int         CNT_W  = $clog2(MAXB + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [1:0]        dev_sel,
  output logic [15:0]       bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_we,
  output logic              bus_re,
  input  logic [DATA_W-1:0] bus_rdata
);
  logic [1:0]       rst_q;
  logic             rst_sync_n;
  logic             sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [15:0]      sub_addr;
  logic [CNT_W-1:0] word_nb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_sync_n = rst_q[1];

  i2c_regport_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_regport_wsize #(
    .SUB_W        (16),
    .CNT_W        (CNT_W),
    .NARROW_BYTES (NARROW_BYTES),
    .WIDE_BYTES   (WIDE_BYTES),
    .WIDE_BASE    (WIDE_BASE)
  ) u_wsize (
    .sub_addr (sub_addr),
    .word_nb  (word_nb)
  );

  i2c_regport_ctrl #(
    .MAXB       (MAXB),
    .CNT_W      (CNT_W),
    .DEV_PREFIX (DEV_PREFIX)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .dev_sel   (dev_sel),
    .word_nb   (word_nb),
    .sub_addr  (sub_addr),
    .sda_oe    (sda_oe),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata)
  );
endmodule

// File: rtl/i2c_regport_chk.sv
module i2c_regport_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_oe,
  input logic bus_we,
  input logic bus_re
);
  // R11: pull-down only starts while the clock line is low
  assert_oe_rise_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i);

  // R5: one write strobe per word, never stretched
  assert_we_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |=> !bus_we);

  // R8: one read strobe per word
  assert_re_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re |=> !bus_re);

  // R4: read and write strobes exclusive
  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_re));
endmodule

bind i2c_regport i2c_regport_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .scl_i  (scl_i),
  .sda_oe (sda_oe),
  .bus_we (bus_we),
  .bus_re (bus_re)
);

// File: tb/i2c_regport_bench.sv
`timescale 1ns/1ps
module i2c_regport_bench;
  localparam int Q = 24;

  logic        clk, rst_n;
  logic        m_scl, m_sda_low;
  logic        sda_oe, bus_we, bus_re;
  logic        sda_line;
  logic [1:0]  dev_sel;
  logic [15:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  int total = 0, bad = 0;
  int we_cnt = 0, re_cnt = 0, oe_cnt = 0, bad_rise = 0;
  logic [15:0] last_we_addr;
  logic        oe_prev;

  logic [31:0] mem  [0:511];
  logic [31:0] expm [0:511];
  logic [7:0]  wb   [0:63];
  logic [7:0]  rb   [0:63];

  assign sda_line = !(m_sda_low || sda_oe);

  i2c_regport u_i2c_regport (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .dev_sel(dev_sel), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata)
  );

  initial begin clk = 0; forever #2 clk = ~clk; end

  function automatic int midx(input logic [15:0] a);
    return int'({a[11], a[7:0]});
  endfunction
  function automatic int nbf(input logic [15:0] a);
    return (a >= 16'h0800) ? 4 : 2;
  endfunction

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 32'h0;
    oe_prev = 1'b0;
  end
  always @(posedge clk) begin
    if (bus_we) begin
      mem[midx(bus_addr)] <= bus_wdata;
      we_cnt <= we_cnt + 1;
      last_we_addr <= bus_addr;
    end
    if (bus_re) re_cnt <= re_cnt + 1;
    bus_rdata <= mem[midx(bus_addr)];
    if (sda_oe) oe_cnt <= oe_cnt + 1;
    if (sda_oe && !oe_prev && m_scl) bad_rise <= bad_rise + 1;
    oe_prev <= sda_oe;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic i2c_start();
    m_sda_low = 0; #Q; m_scl = 1; #Q; m_sda_low = 1; #Q; m_scl = 0; #Q;
  endtask
  task automatic i2c_stop();
    m_sda_low = 1; #Q; m_scl = 1; #Q; m_sda_low = 0; #Q;
  endtask
  task automatic wr_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda_low = !b[i]; #Q; m_scl = 1; #(2*Q); m_scl = 0; #Q;
    end
    m_sda_low = 0; #Q; m_scl = 1; #Q; ack = !sda_line; #Q; m_scl = 0; #Q;
  endtask
  task automatic rd_byte(input bit mack, output logic [7:0] b);
    m_sda_low = 0;
    for (int i = 7; i >= 0; i--) begin
      #Q; m_scl = 1; #Q; b[i] = sda_line; #Q; m_scl = 0; #Q;
    end
    m_sda_low = mack; #Q; m_scl = 1; #(2*Q); m_scl = 0; #Q; m_sda_low = 0;
  endtask

  function automatic logic [7:0] devb(input bit rd);
    return {5'b01101, dev_sel, rd};
  endfunction

  task automatic do_write(input logic [15:0] sub, input int n, output int acks);
    bit a;
    acks = 0;
    i2c_start();
    wr_byte(devb(0), a);     acks += int'(a);
    wr_byte(sub[15:8], a);   acks += int'(a);
    wr_byte(sub[7:0], a);    acks += int'(a);
    for (int k = 0; k < n; k++) begin wr_byte(wb[k], a); acks += int'(a); end
    i2c_stop();
  endtask

  task automatic do_read(input logic [15:0] sub, input int n, output int acks);
    bit a;
    acks = 0;
    i2c_start();
    wr_byte(devb(0), a);   acks += int'(a);
    wr_byte(sub[15:8], a); acks += int'(a);
    wr_byte(sub[7:0], a);  acks += int'(a);
    i2c_start();
    wr_byte(devb(1), a);   acks += int'(a);
    for (int k = 0; k < n; k++) rd_byte(k != n - 1, rb[k]);
    i2c_stop();
  endtask

  function automatic void model_write(input logic [15:0] sub, input int n,
                                      output int words, output logic [15:0] last);
    logic [15:0] a = sub;
    logic [31:0] acc = 0;
    int idx = 0;
    words = 0; last = sub;
    for (int k = 0; k < n; k++) begin
      acc = (acc << 8) | 32'(wb[k]);
      idx++;
      if (idx == nbf(a)) begin
        expm[midx(a)] = acc; last = a; words++;
        a++; idx = 0; acc = 0;
      end
    end
  endfunction

  function automatic logic [7:0] model_rbyte(input logic [15:0] sub, input int k);
    logic [15:0] a = sub;
    int idx = k;
    while (idx >= nbf(a)) begin idx -= nbf(a); a++; end
    return 8'(expm[midx(a)] >> (8 * (nbf(a) - 1 - idx)));
  endfunction

  task automatic write_and_check(input logic [15:0] sub, input int n, input string tag);
    int acks, words, w0;
    logic [15:0] last;
    model_write(sub, n, words, last);
    w0 = we_cnt;
    do_write(sub, n, acks);
    chk(acks == n + 3, "R4", {tag, " acks"}, acks, n + 3);
    chk(we_cnt - w0 == words, "R5", {tag, " write count"}, we_cnt - w0, words);
    if (words > 0) chk(last_we_addr == last, "R6", {tag, " last addr"}, last_we_addr, last);
    for (int k = 0; k < words * nbf(sub); k++) begin
      logic [15:0] a = sub + 16'(k / nbf(sub));
      if (mem[midx(a)] !== expm[midx(a)]) begin
        chk(0, "R5", {tag, " mem word"}, mem[midx(a)], expm[midx(a)]);
        break;
      end
    end
  endtask

  task automatic read_and_check(input logic [15:0] sub, input int n, input string tag);
    int acks, r0, nerr;
    r0 = re_cnt; nerr = 0;
    do_read(sub, n, acks);
    chk(acks == 4, "R8", {tag, " read acks"}, acks, 4);
    for (int k = 0; k < n; k++)
      if (rb[k] !== model_rbyte(sub, k)) begin
        if (nerr == 0) chk(0, "R8", {tag, " read byte"}, rb[k], model_rbyte(sub, k));
        nerr++;
      end
    if (nerr == 0) chk(1, "R8", tag, 0, 0);
    chk(re_cnt - r0 == (n + nbf(sub) - 1) / nbf(sub), "R6", {tag, " read strobes"},
        re_cnt - r0, (n + nbf(sub) - 1) / nbf(sub));
  endtask

  initial begin
    #(200000 * 4);
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit a;
    int acks, w0, r0, o0;
    void'($urandom(32'd4242));
    for (int i = 0; i < 512; i++) expm[i] = 32'h0;
    rst_n = 0; m_scl = 1; m_sda_low = 0; dev_sel = 2'b00;
    #1; #20;
    chk(sda_oe == 0 && bus_we == 0 && bus_re == 0, "R1", "outputs in reset",
        {sda_oe, bus_we, bus_re}, 0);
    #20; rst_n = 1; #40;
    chk(sda_oe == 0 && bus_we == 0 && bus_re == 0, "R1", "outputs after reset",
        {sda_oe, bus_we, bus_re}, 0);

    // R2 each strap setting acknowledged; R3 other straps / prefixes not
    for (int s = 0; s < 4; s++) begin
      dev_sel = 2'(s);
      i2c_start(); wr_byte(devb(0), a); i2c_stop();
      chk(a, "R2", "strap match ack", a, 1);
      i2c_start(); wr_byte({5'b01101, 2'(s + 1), 1'b0}, a); i2c_stop();
      chk(!a, "R3", "strap mismatch nack", a, 0);
    end
    dev_sel = 2'b10;

    // R3 wrong prefix: no ack on later bytes, no strobes
    w0 = we_cnt; o0 = oe_cnt;
    i2c_start(); wr_byte(8'h50, a);
    chk(!a, "R3", "prefix mismatch nack", a, 0);
    acks = 0;
    for (int k = 0; k < 6; k++) begin wr_byte(8'($urandom), a); acks += int'(a); end
    i2c_stop();
    chk(acks == 0 && oe_cnt == o0, "R3", "silent after mismatch", acks, 0);
    chk(we_cnt == w0, "R3", "no write after mismatch", we_cnt - w0, 0);

    // R5 boundary words
    for (int k = 0; k < 8; k++) wb[k] = 8'($urandom);
    write_and_check(16'h07FF, 2, "narrow edge");
    write_and_check(16'h0800, 4, "wide edge");
    read_and_check(16'h07FF, 2, "narrow edge rd");
    read_and_check(16'h0800, 4, "wide edge rd");

    // R7 incomplete word cut by stop
    for (int k = 0; k < 8; k++) wb[k] = 8'($urandom);
    write_and_check(16'h0810, 7, "partial wide");
    chk(mem[midx(16'h0811)] == 32'h0, "R7", "partial word untouched", mem[midx(16'h0811)], 0);
    write_and_check(16'h0020, 1, "partial narrow");

    // R7 incomplete word cut by repeated start; R10 sub kept across restart
    w0 = we_cnt;
    i2c_start(); wr_byte(devb(0), a); wr_byte(8'h08, a); wr_byte(8'h00, a);
    wr_byte(8'hAA, a); wr_byte(8'hBB, a);
    i2c_start(); wr_byte(devb(1), a);
    rd_byte(1, rb[0]); rd_byte(0, rb[1]); i2c_stop();
    chk(we_cnt == w0, "R7", "restart drops partial", we_cnt - w0, 0);
    chk(rb[0] == model_rbyte(16'h0800, 0) && rb[1] == model_rbyte(16'h0800, 1), "R10",
        "sub kept over restart", {rb[0], rb[1]}, {model_rbyte(16'h0800, 0), model_rbyte(16'h0800, 1)});

    // R9 after NACK: released, no read strobe while master keeps clocking
    r0 = re_cnt;
    i2c_start(); wr_byte(devb(1), a); rd_byte(0, rb[0]);
    o0 = oe_cnt;
    for (int k = 0; k < 2; k++) rd_byte(1, rb[1]);
    chk(oe_cnt == o0, "R9", "released after nack", oe_cnt - o0, 0);
    chk(re_cnt - r0 == 1, "R9", "no strobe after nack", re_cnt - r0, 1);
    i2c_stop();

    // R10 after stop, bytes without start are ignored
    o0 = oe_cnt; w0 = we_cnt;
    for (int k = 0; k < 3; k++) wr_byte(devb(0), a);
    chk(oe_cnt == o0 && we_cnt == w0, "R10", "idle after stop", oe_cnt - o0, 0);
    i2c_stop();

    // random bursts in both regions
    for (int it = 0; it < 10; it++) begin
      logic [15:0] sub;
      int nb, words, extra;
      sub = ($urandom % 2) ? 16'h0800 + 16'($urandom % 200) : 16'($urandom % 200);
      nb = nbf(sub);
      words = 1 + int'($urandom % 4);
      extra = int'($urandom % nb);
      for (int k = 0; k < 20; k++) wb[k] = 8'($urandom);
      write_and_check(sub, words * nb + extra, "random");
      read_and_check(sub, words * nb, "random rd");
    end

    chk(bad_rise == 0, "R11", "oe rise while scl high", bad_rise, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule